// File: doc/BRIEF.md
# Fractional-Increment Precision Time Counter

This block keeps a free-running time-of-day value for a precision time protocol clock. The value is 64 bits of whole nanoseconds. Below it sits a 32-bit fraction of a nanosecond. On every clock cycle in which counting is enabled, the block adds a 32.32 fixed-point increment to this 96-bit accumulator. Software trims the clock frequency by rewriting the increment. A typical trim is the base value plus or minus base × ppb / 1e9.

The increment is scaled by a multiplier chosen from the link speed before it is added. The fastest rate uses ×1, the middle rate ×2 and the slow rate ×20. The lowest rate uses ×0, and that stops the clock. Software reaches the block through a 32-bit word interface. Each 64-bit quantity is split into a low word and a high word. Reading the low time word takes a snapshot of the upper half, so a later read of the high word is coherent. Writes to the low words wait in holding registers, and a value takes effect only when its high word is written.

Top module: `ptp_time_counter`

## Requirements
- R1: After reset the time is 0, the fraction is 0, the committed increment is 0x0000_0001_9999_9999, and the control word is 0 (counting off, speed code 0).
- R2: While counting is enabled and no time load occurs, each clock adds increment × multiplier to the 96-bit accumulator {time, fraction}; `time_ns` shows the integer part from the cycle after the edge.
- R3: While the enable bit (control bit 0) is clear, the time does not change, except through a time load.
- R4: The speed code in control bits [2:1] selects the multiplier: 0 → ×1, 1 → ×2, 2 → ×20, 3 → ×0. With code 3 the time holds even while enabled.
- R5: A read at address 0 returns the low 32 bits of the time at that edge and captures the upper 32 bits. A later read at address 1 returns the captured upper half, even if the time has since moved on.
- R6: A write at address 0 only loads a holding register. A write at address 1 loads the time with {wdata, held low word} and clears the fraction. This load takes priority over accumulation in that cycle.
- R7: A write at address 2 only holds the low increment word. A write at address 3 commits {wdata, held low word} as the new increment. Until that commit the old increment stays in use. Reads at addresses 2 and 3 return the committed increment's low and high words.
- R8: Address 4 is the control word: bit 0 is the enable and bits [2:1] are the speed code. It reads back with the other bits zero.
- R9: `reg_rdata` is registered. It updates on the edge that samples `reg_rd` and holds between reads. Reads at addresses 5 to 7 return 0, and writes there change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| time_ns | output | 64 | Current integer nanosecond time |

## Verification
On every cycle, assertions check the following:
- A time load lands exactly, with the fraction cleared.
- Each step is bounded by the scaled increment.
- The time freezes when counting is disabled or the speed code halts it.
- The committed increment, the snapshot and the read data do not move without the access that owns them.

The bench's cycle-accurate model covers the behaviours that need a scenario: carries out of the fraction, the pending-word ordering of both 64-bit registers, and a snapshot that stays coherent across a carry into the high word. It also checks the exact step sizes for each speed code and that unmapped accesses have no effect.

// File: rtl/ptp_tc_pkg.sv
package ptp_tc_pkg;

    // Word addresses of the register interface
    typedef enum logic [2:0] {
        ADR_TIME_LO = 3'd0,
        ADR_TIME_HI = 3'd1,
        ADR_INC_LO  = 3'd2,
        ADR_INC_HI  = 3'd3,
        ADR_CTRL    = 3'd4
    } reg_addr_e;

    // Link-rate multiplier select
    typedef enum logic [1:0] {
        SPD_X1   = 2'd0,
        SPD_X2   = 2'd1,
        SPD_X20  = 2'd2,
        SPD_STOP = 2'd3
    } speed_e;

endpackage

// File: rtl/ptp_tc_incscale.sv
module ptp_tc_incscale
    import ptp_tc_pkg::*;
#(
    parameter int INC_W = 64,
    parameter int OUT_W = INC_W + 5
) (
    input  logic [INC_W-1:0] inc_i,
    input  speed_e           speed_i,
    output logic [OUT_W-1:0] scaled_o
);

    logic [OUT_W-1:0] base_ext;

    always_comb begin
        base_ext = OUT_W'(inc_i);
        case (speed_i)
            SPD_X1:   scaled_o = base_ext;
            SPD_X2:   scaled_o = base_ext << 1;
            SPD_X20:  scaled_o = (base_ext << 4) + (base_ext << 2);
            default:  scaled_o = '0;
        endcase
    end

endmodule

// File: rtl/ptp_tc_accum.sv
module ptp_tc_accum #(
    parameter int TIME_W   = 64,
    parameter int FRAC_W   = 32,
    parameter int SCALED_W = 69
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en_i,
    input  logic                load_i,
    input  logic [TIME_W-1:0]   load_val_i,
    input  logic [SCALED_W-1:0] scaled_i,
    output logic [TIME_W-1:0]   time_o
);

    localparam int ACC_W = TIME_W + FRAC_W;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } acc_state_t;

    acc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.acc = {load_val_i, {FRAC_W{1'b0}}};
        end else if (en_i) begin
            st_d.acc = st_q.acc + ACC_W'(scaled_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign time_o = st_q.acc[ACC_W-1:FRAC_W];

    AST_LOAD_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (time_o == $past(load_val_i)) && (st_q.acc[FRAC_W-1:0] == '0)); // R6

    AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> ((ACC_W'(time_o - $past(time_o)))
                     <= (ACC_W'($past(scaled_i)) >> FRAC_W) + ACC_W'(1))); // R2

endmodule

// File: rtl/ptp_tc_regif.sv
module ptp_tc_regif
    import ptp_tc_pkg::*;
#(
    parameter int          WORD_W   = 32,
    parameter int          ADDR_W   = 3,
    parameter int          TIME_W   = 64,
    parameter int          INC_W    = 64,
    parameter logic [63:0] BASE_INC = 64'h0000_0001_9999_9999
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic [TIME_W-1:0] time_i,
    output logic [WORD_W-1:0] rdata_o,
    output logic [INC_W-1:0]  inc_o,
    output logic              en_o,
    output speed_e            speed_o,
    output logic              load_o,
    output logic [TIME_W-1:0] load_val_o
);

    localparam int THI_W = TIME_W - WORD_W;
    localparam int IHI_W = INC_W - WORD_W;

    typedef struct packed {
        logic [WORD_W-1:0] pend_time_lo;
        logic [WORD_W-1:0] pend_inc_lo;
        logic [INC_W-1:0]  inc;
        logic              en;
        speed_e            speed;
        logic [THI_W-1:0]  snap_hi;
        logic [WORD_W-1:0] rdata;
    } regs_t;

    regs_t r_d, r_q;

    logic sel_tlo, sel_thi, sel_ilo, sel_ihi, sel_ctl;

    always_comb begin
        sel_tlo = (addr_i == ADDR_W'(ADR_TIME_LO));
        sel_thi = (addr_i == ADDR_W'(ADR_TIME_HI));
        sel_ilo = (addr_i == ADDR_W'(ADR_INC_LO));
        sel_ihi = (addr_i == ADDR_W'(ADR_INC_HI));
        sel_ctl = (addr_i == ADDR_W'(ADR_CTRL));
    end

    always_comb begin
        r_d = r_q;
        // read path: one registered stage
        if (rd_i) begin
            if (sel_tlo) begin
                r_d.rdata   = time_i[WORD_W-1:0];
                r_d.snap_hi = time_i[TIME_W-1:WORD_W];
            end else if (sel_thi) begin
                r_d.rdata = WORD_W'(r_q.snap_hi);
            end else if (sel_ilo) begin
                r_d.rdata = r_q.inc[WORD_W-1:0];
            end else if (sel_ihi) begin
                r_d.rdata = WORD_W'(r_q.inc[INC_W-1:WORD_W]);
            end else if (sel_ctl) begin
                r_d.rdata = {{(WORD_W-3){1'b0}}, r_q.speed, r_q.en};
            end else begin
                r_d.rdata = '0;
            end
        end
        // write path: low words wait, high words commit
        if (wr_i) begin
            if (sel_tlo) r_d.pend_time_lo = wdata_i;
            if (sel_ilo) r_d.pend_inc_lo  = wdata_i;
            if (sel_ihi) r_d.inc          = {wdata_i[IHI_W-1:0], r_q.pend_inc_lo};
            if (sel_ctl) begin
                r_d.en    = wdata_i[0];
                r_d.speed = speed_e'(wdata_i[2:1]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q              <= '0;
            r_q.inc          <= INC_W'(BASE_INC);
            r_q.speed        <= SPD_X1;
        end else begin
            r_q <= r_d;
        end
    end

    assign load_o     = wr_i && sel_thi;
    assign load_val_o = {wdata_i[THI_W-1:0], r_q.pend_time_lo};
    assign rdata_o    = r_q.rdata;
    assign inc_o      = r_q.inc;
    assign en_o       = r_q.en;
    assign speed_o    = r_q.speed;

    AST_INC_COMMIT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && sel_ihi) |=> $stable(inc_o)); // R7

    AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_i && sel_tlo) |=> $stable(r_q.snap_hi)); // R5

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> $stable(rdata_o)); // R9

endmodule

// File: rtl/ptp_time_counter.sv
module ptp_time_counter
    import ptp_tc_pkg::*;
#(
    parameter int          WORD_W   = 32,
    parameter int          ADDR_W   = 3,
    parameter int          TIME_W   = 64,
    parameter int          FRAC_W   = 32,
    parameter logic [63:0] BASE_INC = 64'h0000_0001_9999_9999
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic [TIME_W-1:0] time_ns
);

    localparam int INC_W    = 2 * WORD_W;
    localparam int SCALED_W = INC_W + 5;

    logic [INC_W-1:0]    inc_q;
    logic                en_q;
    speed_e              speed_q;
    logic                load;
    logic [TIME_W-1:0]   load_val;
    logic [SCALED_W-1:0] scaled;

    ptp_tc_regif #(
        .WORD_W   (WORD_W),
        .ADDR_W   (ADDR_W),
        .TIME_W   (TIME_W),
        .INC_W    (INC_W),
        .BASE_INC (BASE_INC)
    ) u_regif (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (reg_wr),
        .rd_i       (reg_rd),
        .addr_i     (reg_addr),
        .wdata_i    (reg_wdata),
        .time_i     (time_ns),
        .rdata_o    (reg_rdata),
        .inc_o      (inc_q),
        .en_o       (en_q),
        .speed_o    (speed_q),
        .load_o     (load),
        .load_val_o (load_val)
    );

    ptp_tc_incscale #(
        .INC_W (INC_W),
        .OUT_W (SCALED_W)
    ) u_scale (
        .inc_i    (inc_q),
        .speed_i  (speed_q),
        .scaled_o (scaled)
    );

    ptp_tc_accum #(
        .TIME_W   (TIME_W),
        .FRAC_W   (FRAC_W),
        .SCALED_W (SCALED_W)
    ) u_accum (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en_q),
        .load_i     (load),
        .load_val_i (load_val),
        .scaled_i   (scaled),
        .time_o     (time_ns)
    );

    AST_DISABLED_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !load) |=> $stable(time_ns)); // R3

    AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && speed_q == SPD_STOP && !load) |=> $stable(time_ns)); // R4

endmodule

// File: tb/ptp_time_counter_bench.sv
module ptp_time_counter_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [63:0] time_ns;

    int n_tests = 0;
    int n_fail  = 0;

    // reference model state
    bit [95:0] m_acc;
    bit [63:0] m_inc;
    bit        m_en;
    bit [1:0]  m_spd;
    bit [31:0] m_ptl, m_pil, m_snap, m_rdata;

    localparam bit [63:0] BASE = 64'h0000_0001_9999_9999;

    always #10 clk = ~clk;

    ptp_time_counter u_ptp_time_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .time_ns   (time_ns)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit [95:0] scaled_inc(input bit [63:0] inc, input bit [1:0] spd);
        int mult;
        case (spd)
            2'd0: mult = 1;
            2'd1: mult = 2;
            2'd2: mult = 20;
            default: mult = 0;
        endcase
        return {32'b0, inc} * 96'(mult);
    endfunction

    // one clock: drive, advance model, compare
    task automatic step(input bit wr, input bit rd, input bit [2:0] a, input bit [31:0] d, input string tag);
        bit [63:0] old_t;
        bit [95:0] sc;
        @(negedge clk);
        reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        old_t = m_acc[95:32];
        sc    = scaled_inc(m_inc, m_spd);
        if (rd) begin
            case (a)
                3'd0: begin m_rdata = old_t[31:0]; m_snap = old_t[63:32]; end
                3'd1: m_rdata = m_snap;
                3'd2: m_rdata = m_inc[31:0];
                3'd3: m_rdata = m_inc[63:32];
                3'd4: m_rdata = {29'b0, m_spd, m_en};
                default: m_rdata = 32'h0;
            endcase
        end
        if (wr && a == 3'd1) m_acc = {d, m_ptl, 32'b0};
        else if (m_en)       m_acc = m_acc + sc;
        if (wr) begin
            case (a)
                3'd0: m_ptl = d;
                3'd2: m_pil = d;
                3'd3: m_inc = {d, m_pil};
                3'd4: begin m_en = d[0]; m_spd = d[2:1]; end
                default: ;
            endcase
        end
        #1;
        chk(time_ns == m_acc[95:32], {tag, " time"}, time_ns, m_acc[95:32]);
        chk(reg_rdata == m_rdata, {tag, " rdata"}, 64'(reg_rdata), 64'(m_rdata));
        reg_wr = 1'b0; reg_rd = 1'b0;
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, 0, 3'd0, 32'h0, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] t0;
        bit   [63:0] trim;
        m_acc = '0; m_inc = BASE; m_en = 0; m_spd = 0;
        m_ptl = 0; m_pil = 0; m_snap = 0; m_rdata = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset values
        step(0, 0, 3'd0, 0, "R1");
        chk(time_ns == 64'h0, "R1 reset time", time_ns, 64'h0);
        step(0, 1, 3'd2, 0, "R1 inc lo");
        step(0, 1, 3'd3, 0, "R1 inc hi");
        chk(reg_rdata == 32'h1, "R1 inc hi value", 64'(reg_rdata), 64'h1);
        step(0, 1, 3'd4, 0, "R1 ctrl");
        idle(5, "R3 off at reset");

        // R8/R2: enable at x1
        step(1, 0, 3'd4, 32'h1, "R8 ctrl write");
        step(0, 1, 3'd4, 0, "R8 ctrl read");
        chk(reg_rdata == 32'h1, "R8 ctrl value", 64'(reg_rdata), 64'h1);
        idle(20, "R2 x1");

        // R6: pending low time word
        step(1, 0, 3'd0, 32'hFFFF_FFF0, "R6 lo pending");
        idle(3, "R6 still counting");
        step(1, 0, 3'd1, 32'h1, "R6 commit");
        chk(time_ns == 64'h1_FFFF_FFF0, "R6 loaded", time_ns, 64'h1_FFFF_FFF0);

        // R5: snapshot across carry into upper word
        step(0, 1, 3'd0, 0, "R5 lo read");
        idle(20, "R5 carry");
        step(0, 1, 3'd1, 0, "R5 hi read");
        chk(reg_rdata == 32'h1, "R5 snapshot hi", 64'(reg_rdata), 64'h1);
        chk(time_ns[63:32] == 32'h2, "R5 time moved on", 64'(time_ns[63:32]), 64'h2);

        // R4: speed codes
        step(1, 0, 3'd4, 32'h3, "R4 x2");
        idle(15, "R4 x2 run");
        step(1, 0, 3'd4, 32'h5, "R4 x20");
        idle(15, "R4 x20 run");
        step(1, 0, 3'd4, 32'h7, "R4 stop");
        t0 = time_ns;
        idle(10, "R4 stop run");
        chk(time_ns == t0, "R4 halted", time_ns, t0);

        // R3: disabled
        step(1, 0, 3'd4, 32'h0, "R3 disable");
        t0 = time_ns;
        idle(10, "R3 off run");
        chk(time_ns == t0, "R3 held", time_ns, t0);

        // R7: increment trim, low word pending
        trim = BASE + (BASE * 64'd100000) / 64'd1000000000;
        step(1, 0, 3'd4, 32'h1, "R7 enable x1");
        step(1, 0, 3'd2, trim[31:0], "R7 lo pending");
        idle(8, "R7 old inc");
        step(0, 1, 3'd2, 0, "R7 lo not committed");
        chk(reg_rdata == BASE[31:0], "R7 inc lo old", 64'(reg_rdata), 64'(BASE[31:0]));
        step(1, 0, 3'd3, trim[63:32], "R7 commit");
        step(0, 1, 3'd2, 0, "R7 lo read");
        chk(reg_rdata == trim[31:0], "R7 inc lo new", 64'(reg_rdata), 64'(trim[31:0]));
        idle(20, "R7 new inc");

        // R9: unmapped address
        step(1, 0, 3'd5, 32'hFFFF_FFFF, "R9 unmapped write");
        step(0, 1, 3'd5, 0, "R9 unmapped read");
        chk(reg_rdata == 32'h0, "R9 zero read", 64'(reg_rdata), 64'h0);
        step(0, 1, 3'd4, 0, "R9 ctrl intact");
        chk(reg_rdata == 32'h1, "R9 ctrl intact value", 64'(reg_rdata), 64'h1);
        idle(5, "R9 rdata hold");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule